// File: doc/BRIEF.md
# Five-Segment Discontinuous Space-Vector PWM Generator

This block turns a two-axis voltage reference into three ideal inverter leg states. Each axis is a 9-bit unsigned code in which 224 means zero. The block runs its own triangular carrier and takes a new reference at every carrier valley. From that reference it works out the sector with three sign tests. It then computes two comparison thresholds: the first active-vector time, and the sum of both active-vector times. For the rest of the carrier period it compares those thresholds against the carrier.

In every carrier period exactly one leg is held constant. In sectors 1, 3 and 5 that leg is held high and the all-ones null state fills the centre of the period. In sectors 2, 4 and 6 that leg is held low and the all-zeros null state fills the centre. The other two legs switch symmetrically about the carrier peak. The outputs are the raw leg states with no dead time, plus the latched sector number. Downstream logic adds the gate-drive timing.

Top module: `svpwm5_gen`

## Requirements
- R1: While rst_ni is low, and afterwards until the first carrier valley latch, sector_o is 0 and all three leg outputs are 0. The first latch happens at the 416th rising clock edge after reset is released, and sector_o shows the new sector right after that edge.
- R2: The carrier advances one step every 13 clocks, and a period has 32 steps. Step k has the value 224+8k for k<16 and 352−8(k−16) for k≥16. Step 0 is the valley, and a period starts at step 0 after reset and after every latch.
- R3: Let a=alpha_i−224, b=beta_i−224 and r=floor(443·a/256). The three flags (b>0, b>r, b>−r) select the sector: 1,0,1 gives 1; 1,1,1 gives 2; 1,1,0 gives 3; 0,1,0 gives 4; 0,0,0 gives 5; 0,0,1 gives 6.
- R4: Let p=3a and x=floor(443·b/256). The doubled times (D1, D2) depend on the sector: 1 → (p−x, 2x); 2 → (p+x, x−p); 3 → (2x, −p−x); 4 → (x−p, −2x); 5 → (−p−x, p−x); 6 → (−2x, p+x). The near threshold is 224+clamp(floor(D1/2)) and the far threshold is 224+clamp(floor((D1+D2)/2)), where clamp limits a value to the range 0..128.
- R5: In sectors 1, 3 and 5 the clamped leg is 1. Each other leg is 1 exactly while the carrier is strictly above its threshold.
- R6: In sectors 2, 4 and 6 the clamped leg is 0. Each other leg is 1 exactly while the carrier is strictly below its threshold.
- R7: The roles of the legs (clamped, near threshold, far threshold) depend on the sector. Sectors 1 and 4 use (A, B, C), sectors 2 and 5 use (C, A, B), and sectors 3 and 6 use (B, C, A). Leg A drives sa_o, leg B drives sb_o and leg C drives sc_o.
- R8: Sector and thresholds are captured only at the clock edge where the carrier wraps from step 31 to step 0. Input changes inside a period have no effect on the legs or on sector_o until that edge.
- R9: The leg outputs are registered. Each one reflects the carrier step that was in effect one clock earlier, so a leg can change only on the clock after a carrier step.
- R10: A reference too large for the carrier span saturates both thresholds at 352, so in an odd sector the two unclamped legs stay low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alpha_i | input | 9 | Alpha-axis reference code, 224 = zero |
| beta_i | input | 9 | Beta-axis reference code, 224 = zero |
| sa_o | output | 1 | Leg A switching state |
| sb_o | output | 1 | Leg B switching state |
| sc_o | output | 1 | Leg C switching state |
| sector_o | output | 3 | Latched sector 1..6, 0 before the first latch |

## Verification
The bench counts rising edges after reset is released and samples on falling edges. Latches therefore fall on edge counts that are multiples of 416, and sector_o is read at the falling edge just after such an edge. The leg sampled after edge L+1+j, where L is the latch edge, is compared with the carrier step floor(j/13). This accounts for the one-register delay from carrier to leg. A reference is changed in the middle of one period to show that it first appears at the next latch edge and not before.

// File: rtl/svpwm5_pkg.sv
package svpwm5_pkg;

    localparam int NUM_LEGS = 3;

    typedef enum logic [1:0] {
        LEG_A = 2'd0,
        LEG_B = 2'd1,
        LEG_C = 2'd2
    } leg_e;

    // Role of each leg within one sector
    typedef struct packed {
        leg_e clamp;
        leg_e near;
        leg_e far;
    } leg_plan_t;

    function automatic leg_plan_t plan_for(input logic [2:0] sec);
        leg_plan_t p;
        case (sec)
            3'd2, 3'd5: p = '{clamp: LEG_C, near: LEG_A, far: LEG_B};
            3'd3, 3'd6: p = '{clamp: LEG_B, near: LEG_C, far: LEG_A};
            default:    p = '{clamp: LEG_A, near: LEG_B, far: LEG_C};
        endcase
        return p;
    endfunction

    // flags = {b > 0, b > r, b > -r}
    function automatic logic [2:0] sector_from_flags(input logic [2:0] flags);
        logic [2:0] s;
        case (flags)
            3'b101:  s = 3'd1;
            3'b111:  s = 3'd2;
            3'b110:  s = 3'd3;
            3'b010:  s = 3'd4;
            3'b000:  s = 3'd5;
            3'b001:  s = 3'd6;
            default: s = 3'd5;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/svpwm5_carrier.sv
module svpwm5_carrier #(
    parameter int CLK_DIV = 13,
    parameter int STEPS   = 32,
    parameter int CODE_W  = 9,
    parameter int CAR_LO  = 224,
    parameter int CAR_HI  = 352
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic              tick_o,
    output logic              valley_o,
    output logic [CODE_W-1:0] carrier_o
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int PH_W  = $clog2(STEPS);
    localparam int HALF  = STEPS / 2;
    localparam int STEP  = (CAR_HI - CAR_LO) / HALF;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PH_W-1:0]  ph;
    } car_st_t;

    car_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        tick_o   = (st_q.div == DIV_W'(CLK_DIV - 1));
        valley_o = tick_o && (st_q.ph == PH_W'(STEPS - 1));
        if (tick_o) begin
            st_d.div = '0;
            st_d.ph  = (st_q.ph == PH_W'(STEPS - 1)) ? '0 : st_q.ph + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
        if (st_q.ph < PH_W'(HALF)) begin
            carrier_o = CODE_W'(CAR_LO + STEP * int'(st_q.ph));
        end else begin
            carrier_o = CODE_W'(CAR_HI - STEP * (int'(st_q.ph) - HALF));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/svpwm5_sector.sv
module svpwm5_sector
    import svpwm5_pkg::*;
#(
    parameter int DW    = 20,
    parameter int K_NUM = 443,
    parameter int K_SH  = 8
) (
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    output logic [2:0]           sector_o
);

    localparam logic signed [DW-1:0] K_C = DW'(K_NUM);

    logic signed [DW-1:0] a_k;
    logic signed [DW-1:0] a_k_neg;
    logic [2:0]           flags;

    always_comb begin
        a_k      = (a_i * K_C) >>> K_SH;
        a_k_neg  = -a_k;
        flags    = {b_i > 0, b_i > a_k, b_i > a_k_neg};
        sector_o = sector_from_flags(flags);
    end

endmodule

// File: rtl/svpwm5_duration.sv
module svpwm5_duration #(
    parameter int DW     = 20,
    parameter int K_NUM  = 443,
    parameter int K_SH   = 8,
    parameter int CODE_W = 9,
    parameter int CAR_LO = 224,
    parameter int CAR_HI = 352
) (
    input  logic [2:0]           sector_i,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    output logic [CODE_W-1:0]    ta_o,
    output logic [CODE_W-1:0]    tab_o
);

    localparam int SPAN = CAR_HI - CAR_LO;
    localparam logic signed [DW-1:0] K_C    = DW'(K_NUM);
    localparam logic signed [DW-1:0] SPAN_C = DW'(SPAN);

    logic signed [DW-1:0] p3;
    logic signed [DW-1:0] xk;
    logic signed [DW-1:0] d1;
    logic signed [DW-1:0] d2;

    function automatic logic [CODE_W-1:0] to_code(input logic signed [DW-1:0] v);
        logic signed [DW-1:0] c;
        if (v < 0) begin
            c = '0;
        end else if (v > SPAN_C) begin
            c = SPAN_C;
        end else begin
            c = v;
        end
        return CODE_W'(CAR_LO) + CODE_W'(c);
    endfunction

    always_comb begin
        p3 = a_i + (a_i <<< 1);
        xk = (b_i * K_C) >>> K_SH;
        case (sector_i)
            3'd1:    begin d1 = p3 - xk;  d2 = xk <<< 1;   end
            3'd2:    begin d1 = p3 + xk;  d2 = xk - p3;    end
            3'd3:    begin d1 = xk <<< 1; d2 = -p3 - xk;   end
            3'd4:    begin d1 = xk - p3;  d2 = -(xk <<< 1); end
            3'd5:    begin d1 = -p3 - xk; d2 = p3 - xk;    end
            3'd6:    begin d1 = -(xk <<< 1); d2 = p3 + xk; end
            default: begin d1 = '0;       d2 = '0;         end
        endcase
        ta_o  = to_code(d1 >>> 1);
        tab_o = to_code((d1 + d2) >>> 1);
    end

endmodule

// File: rtl/svpwm5_legs.sv
module svpwm5_legs
    import svpwm5_pkg::*;
#(
    parameter int CODE_W = 9
) (
    input  logic [2:0]          sector_i,
    input  logic [CODE_W-1:0]   carrier_i,
    input  logic [CODE_W-1:0]   ta_i,
    input  logic [CODE_W-1:0]   tab_i,
    output logic [NUM_LEGS-1:0] legs_o
);

    leg_plan_t plan;
    logic      odd;
    logic      live;

    assign plan = plan_for(sector_i);
    assign odd  = sector_i[0];
    assign live = (sector_i != 3'd0) && (sector_i != 3'd7);

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic bit_w;
        logic near_hit;
        logic far_hit;

        always_comb begin
            near_hit = odd ? (carrier_i > ta_i)  : (carrier_i < ta_i);
            far_hit  = odd ? (carrier_i > tab_i) : (carrier_i < tab_i);
            if (!live) begin
                bit_w = 1'b0;
            end else if (plan.clamp == leg_e'(g)) begin
                bit_w = odd;
            end else if (plan.near == leg_e'(g)) begin
                bit_w = near_hit;
            end else if (plan.far == leg_e'(g)) begin
                bit_w = far_hit;
            end else begin
                bit_w = 1'b0;
            end
        end

        assign legs_o[g] = bit_w;
    end

endmodule

// File: rtl/svpwm5_gen.sv
module svpwm5_gen
    import svpwm5_pkg::*;
#(
    parameter int CODE_W  = 9,
    parameter int CAR_LO  = 224,
    parameter int CAR_HI  = 352,
    parameter int STEPS   = 32,
    parameter int CLK_DIV = 13,
    parameter int K_NUM   = 443,
    parameter int K_SH    = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] alpha_i,
    input  logic [CODE_W-1:0] beta_i,
    output logic              sa_o,
    output logic              sb_o,
    output logic              sc_o,
    output logic [2:0]        sector_o
);

    localparam int DW = CODE_W + 2 + $clog2(K_NUM + 1);
    localparam logic signed [DW-1:0] ZERO_C = DW'(CAR_LO);

    typedef struct packed {
        logic [2:0]          sector;
        logic [CODE_W-1:0]   ta;
        logic [CODE_W-1:0]   tab;
        logic [NUM_LEGS-1:0] legs;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic                 tick_w;
    logic                 valley_w;
    logic [CODE_W-1:0]    carrier_w;
    logic signed [DW-1:0] a_w;
    logic signed [DW-1:0] b_w;
    logic [2:0]           sec_w;
    logic [CODE_W-1:0]    ta_w;
    logic [CODE_W-1:0]    tab_w;
    logic [NUM_LEGS-1:0]  legs_w;

    assign a_w = $signed(DW'(alpha_i)) - ZERO_C;
    assign b_w = $signed(DW'(beta_i)) - ZERO_C;

    svpwm5_carrier #(
        .CLK_DIV (CLK_DIV),
        .STEPS   (STEPS),
        .CODE_W  (CODE_W),
        .CAR_LO  (CAR_LO),
        .CAR_HI  (CAR_HI)
    ) u_carrier (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_o    (tick_w),
        .valley_o  (valley_w),
        .carrier_o (carrier_w)
    );

    svpwm5_sector #(
        .DW    (DW),
        .K_NUM (K_NUM),
        .K_SH  (K_SH)
    ) u_sector (
        .a_i      (a_w),
        .b_i      (b_w),
        .sector_o (sec_w)
    );

    svpwm5_duration #(
        .DW     (DW),
        .K_NUM  (K_NUM),
        .K_SH   (K_SH),
        .CODE_W (CODE_W),
        .CAR_LO (CAR_LO),
        .CAR_HI (CAR_HI)
    ) u_duration (
        .sector_i (sec_w),
        .a_i      (a_w),
        .b_i      (b_w),
        .ta_o     (ta_w),
        .tab_o    (tab_w)
    );

    svpwm5_legs #(
        .CODE_W (CODE_W)
    ) u_legs (
        .sector_i  (st_q.sector),
        .carrier_i (carrier_w),
        .ta_i      (st_q.ta),
        .tab_i     (st_q.tab),
        .legs_o    (legs_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.legs = legs_w;
        if (valley_w) begin
            st_d.sector = sec_w;
            st_d.ta     = ta_w;
            st_d.tab    = tab_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sa_o     = st_q.legs[0];
    assign sb_o     = st_q.legs[1];
    assign sc_o     = st_q.legs[2];
    assign sector_o = st_q.sector;

endmodule

// File: rtl/svpwm5_chk.sv
module svpwm5_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] sector_i,
    input logic [2:0] legs_i,
    input logic       tick_i,
    input logic       valley_i
);

    // R1
    idle_legs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sector_i == 3'd0) |-> (legs_i == 3'b000));

    // R3
    sector_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sector_i) != 3'd0) |-> (sector_i != 3'd0 && sector_i <= 3'd6));

    // R8
    sector_valley_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sector_i) |-> $past(valley_i));

    // R5 R7
    clamp_s1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sector_i == 3'd1 && $stable(sector_i)) |-> legs_i[2]);

    // R5 R7
    clamp_s3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sector_i == 3'd3 && $stable(sector_i)) |-> legs_i[1]);

    // R5 R7
    clamp_s5_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sector_i == 3'd5 && $stable(sector_i)) |-> legs_i[0]);

    // R6 R7
    clamp_s2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sector_i == 3'd2 && $stable(sector_i)) |-> !legs_i[0]);

    // R6 R7
    clamp_s4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sector_i == 3'd4 && $stable(sector_i)) |-> !legs_i[2]);

    // R6 R7
    clamp_s6_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sector_i == 3'd6 && $stable(sector_i)) |-> !legs_i[1]);

    // R9
    legs_after_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(legs_i) |-> $past(tick_i, 2));

endmodule

bind svpwm5_gen svpwm5_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sector_i (sector_o),
    .legs_i   ({sa_o, sb_o, sc_o}),
    .tick_i   (tick_w),
    .valley_i (valley_w)
);

// File: tb/svpwm5_gen_tb_top.sv
module svpwm5_gen_tb_top;

    localparam int PERIOD_CYC = 13 * 32;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] alpha = 9'd224;
    logic [8:0] beta  = 9'd224;
    logic       sa;
    logic       sb;
    logic       sc;
    logic [2:0] sector;

    int cyc    = 0;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    svpwm5_gen dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .alpha_i  (alpha),
        .beta_i   (beta),
        .sa_o     (sa),
        .sb_o     (sb),
        .sc_o     (sc),
        .sector_o (sector)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic int car_of(input int ph);
        return (ph < 16) ? 224 + 8 * ph : 352 - 8 * (ph - 16);
    endfunction

    function automatic int clampi(input int v);
        return (v < 0) ? 0 : ((v > 128) ? 128 : v);
    endfunction

    task automatic model(input int al, input int be, output int sec, output int ta, output int tab);
        int a, b, r, x, p, f, d1, d2;
        a = al - 224;
        b = be - 224;
        r = (a * 443) >>> 8;
        x = (b * 443) >>> 8;
        p = 3 * a;
        f = 0;
        if (b > 0)  f += 4;
        if (b > r)  f += 2;
        if (b > -r) f += 1;
        case (f)
            5: sec = 1;
            7: sec = 2;
            6: sec = 3;
            2: sec = 4;
            1: sec = 6;
            default: sec = 5;
        endcase
        case (sec)
            1: begin d1 = p - x;  d2 = 2 * x;  end
            2: begin d1 = p + x;  d2 = x - p;  end
            3: begin d1 = 2 * x;  d2 = -p - x; end
            4: begin d1 = x - p;  d2 = -2 * x; end
            5: begin d1 = -p - x; d2 = p - x;  end
            default: begin d1 = -2 * x; d2 = p + x; end
        endcase
        ta  = 224 + clampi(d1 >>> 1);
        tab = 224 + clampi((d1 + d2) >>> 1);
    endtask

    // leg 0 = A, 1 = B, 2 = C (R7 table)
    function automatic bit leg_exp(input int sec, input int ta, input int tab, input int car, input int leg);
        int cl, nr, thr;
        bit odd;
        case (sec)
            2, 5: begin cl = 2; nr = 0; end
            3, 6: begin cl = 1; nr = 2; end
            default: begin cl = 0; nr = 1; end
        endcase
        odd = (sec % 2) == 1;
        if (leg == cl) return odd;
        thr = (leg == nr) ? ta : tab;
        return odd ? (car > thr) : (car < thr);
    endfunction

    task automatic t_reset();
        int bad;
        bad = 0;
        repeat (3) @(negedge clk);
        chk(sector == 3'd0 && {sa, sb, sc} == 3'b000, "R1 outputs in reset", {sector, sa, sb, sc}, 0);
        rst_n = 1'b1;
        do begin
            @(negedge clk);
            if (cyc < PERIOD_CYC && (sector != 3'd0 || {sa, sb, sc} != 3'b000)) bad++;
        end while (cyc < PERIOD_CYC - 1);
        chk(bad == 0, "R1 idle before first latch", bad, 0);
        @(negedge clk);
        chk(sector == 3'd5, "R1 R3 first latch at edge 416", sector, 5);
    endtask

    task automatic run_period(input string tag, input int al, input int be, input int exp_sec,
                              input int al2, input int be2, input int exp_sec2);
        int sec, ta, tab, moved;
        int bad[3];
        int fa[3];
        int fe[3];
        bit got[3];
        moved = 0;
        for (int k = 0; k < 3; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
        @(negedge clk);
        alpha = 9'(al);
        beta  = 9'(be);
        do @(negedge clk); while (cyc % PERIOD_CYC != 0);
        chk(sector == 3'(exp_sec), {tag, " R3 sector"}, sector, exp_sec);
        model(al, be, sec, ta, tab);
        for (int j = 0; j < PERIOD_CYC; j++) begin
            @(negedge clk);
            got[0] = sa;
            got[1] = sb;
            got[2] = sc;
            for (int k = 0; k < 3; k++) begin
                bit e;
                e = leg_exp(sec, ta, tab, car_of(j / 13), k);
                if (got[k] != e) begin
                    if (bad[k] == 0) begin fa[k] = got[k]; fe[k] = e; end
                    bad[k]++;
                end
            end
            if (j < PERIOD_CYC - 1 && sector != 3'(exp_sec)) moved++;
            if (al2 >= 0 && j == 200) begin
                alpha = 9'(al2);
                beta  = 9'(be2);
            end
        end
        chk(bad[0] == 0, {tag, " R2 R4 R5 R6 R7 R9 leg A"}, fa[0], fe[0]);
        chk(bad[1] == 0, {tag, " R2 R4 R5 R6 R7 R9 leg B"}, fa[1], fe[1]);
        chk(bad[2] == 0, {tag, " R2 R4 R5 R6 R7 R9 leg C"}, fa[2], fe[2]);
        chk(moved == 0, {tag, " R8 sector steady in period"}, moved, 0);
        if (al2 >= 0) begin
            chk(sector == 3'(exp_sec2), {tag, " R8 new sector at next valley"}, sector, exp_sec2);
        end
    endtask

    initial begin
        t_reset();
        run_period("s1 30deg",  267, 249, 1, -1, -1, 0);
        run_period("s2 90deg",  224, 274, 2, -1, -1, 0);
        run_period("s3 150deg", 181, 249, 3, -1, -1, 0);
        run_period("s4 210deg", 181, 199, 4, -1, -1, 0);
        run_period("s5 270deg", 224, 174, 5, -1, -1, 0);
        run_period("s6 330deg", 267, 199, 6, -1, -1, 0);
        run_period("zero ref",  224, 224, 5, -1, -1, 0);
        run_period("R3 boundary b=0", 304, 224, 6, -1, -1, 0);
        run_period("R10 saturation", 374, 244, 1, -1, -1, 0);
        run_period("R8 mid change", 267, 249, 1, 181, 199, 4);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

endmodule